// File: doc/BRIEF.md
# PLL Control Registers with Feed-Sequence Commit

This block is the register front end for a clock-multiplying PLL. Software writes two holding registers: a control word with an enable bit and a connect bit, and a configuration word with a multiplier select (M) and a divider select (P). Nothing written there reaches the PLL right away. The held values move into shadow registers only when software writes a two-word key to a write-only feed register. The shadow registers drive the PLL pins: M sets the feedback divide, and P sets the post-oscillator divide of 2P.

A read-only status register shows the committed shadow settings together with the lock flag. It never shows pending writes, so software can read status to tell whether a feed has happened. The lock input passes through a two-flop synchronizer. The clock-select output chooses the PLL clock only when the PLL is enabled, connected and locked. Otherwise it chooses the bypass clock.

The bus is a plain synchronous register port. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. `bus_rd` marks a read access so that the feed detector can see it.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset the control holding word, the configuration holding word, all shadow outputs, the status word and `clk_sel` are zero.
- R2: A write to offset 0x0 stores bit 0 (enable) and bit 1 (connect) in the control holding word, which reads back at 0x0. It does not change the shadow outputs or status.
- R3: A write to offset 0x4 stores bits 4:0 (M) and bits 6:5 (P) in the configuration holding word, which reads back at 0x4 with every other bit zero. It does not change the shadow outputs or status.
- R4: Two consecutive bus accesses that write 0xAA to offset 0xC and then 0x55 to offset 0xC copy both holding words into the shadow outputs `pll_en`, `pll_conn`, `pll_m` and `pll_p`. The copy is visible after the clock edge of the 0x55 write.
- R5: No commit happens in any of these cases: a wrong key value, 0x55 with no 0xAA before it, or any read or write to another register between 0xAA and 0x55.
- R6: Status at offset 0x8 has shadow M at bits 4:0, shadow P at bits 6:5, shadow enable at bit 8, shadow connect at bit 9 and the synchronized lock flag at bit 10. All other bits are zero.
- R7: A change on `lock_in` appears in status bit 10 after exactly two rising clock edges.
- R8: `clk_sel` is 1 only when shadow enable, shadow connect and the synchronized lock flag are all 1.
- R9: A read of the feed register at offset 0xC returns zero.
- R10: Cycles with no bus access between the 0xAA and 0x55 writes do not break the feed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read access marker |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| pll_en | output | 1 | Shadow enable |
| pll_conn | output | 1 | Shadow connect |
| pll_m | output | 5 | Shadow multiplier select |
| pll_p | output | 2 | Shadow divider select |
| clk_sel | output | 1 | 1 selects the PLL clock, 0 selects the bypass clock |

## Verification
Results are due at three different times:
- Holding writes and feed commits are visible one edge after the write, so the bench drives each access on a falling edge and checks at the next falling edge.
- Read data is combinational and is sampled one nanosecond after the address is set.
- A lock change needs two edges. The bench checks status bit 10 after the first edge, where it must not have changed yet, and after the second, where it must have.

// File: rtl/pll_feed_regs.sv
module pll_feed_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int M_W = 5,
  parameter int P_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lock_in,
  output logic              pll_en,
  output logic              pll_conn,
  output logic [M_W-1:0]    pll_m,
  output logic [P_W-1:0]    pll_p,
  output logic              clk_sel
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(4'hC);
  localparam logic [DATA_W-1:0] KEY_A = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] KEY_B = DATA_W'(8'h55);
  localparam int CFG_W = M_W + P_W;
  localparam int EN_BIT = 8;
  localparam int CONN_BIT = 9;
  localparam int LOCK_BIT = 10;

  logic [1:0]            ctl_hold;
  logic [CFG_W-1:0]      cfg_hold;
  logic                  armed;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                  lock_s;

  wire access  = bus_wr | bus_rd;
  wire feed_wr = bus_wr && (bus_addr == A_FEED);
  wire key_a   = feed_wr && (bus_wdata == KEY_A);
  wire commit  = armed && feed_wr && (bus_wdata == KEY_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_hold <= '0;
      cfg_hold <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTL) ctl_hold <= bus_wdata[1:0];
      if (bus_addr == A_CFG) cfg_hold <= bus_wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (access) armed <= key_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_en   <= 1'b0;
      pll_conn <= 1'b0;
      pll_m    <= '0;
      pll_p    <= '0;
    end else if (commit) begin
      pll_en   <= ctl_hold[0];
      pll_conn <= ctl_hold[1];
      pll_m    <= cfg_hold[M_W-1:0];
      pll_p    <= cfg_hold[CFG_W-1:M_W];
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= lock_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], lock_in};
      end
    end
  endgenerate

  assign lock_s  = sync_q[SYNC_STAGES-1];
  assign clk_sel = pll_en & pll_conn & lock_s;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: bus_rdata[1:0] = ctl_hold;
      A_CFG: bus_rdata[CFG_W-1:0] = cfg_hold;
      A_STAT: begin
        bus_rdata[CFG_W-1:0] = {pll_p, pll_m};
        bus_rdata[EN_BIT]    = pll_en;
        bus_rdata[CONN_BIT]  = pll_conn;
        bus_rdata[LOCK_BIT]  = lock_s;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

module pll_feed_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int M_W = 5,
  parameter int P_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              lock_in,
  input logic              pll_en,
  input logic              pll_conn,
  input logic [M_W-1:0]    pll_m,
  input logic [P_W-1:0]    pll_p,
  input logic              clk_sel
);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] C_FEED = ADDR_W'(4'hC);
  localparam logic [DATA_W-1:0] C_KEYB = DATA_W'(8'h55);

  wire key_b_wr = bus_wr && (bus_addr == C_FEED) && (bus_wdata == C_KEYB);

  // R4 R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_b_wr |=> $stable({pll_en, pll_conn, pll_m, pll_p}));

  // R8
  sel_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (pll_en && pll_conn));

  // R7
  sel_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> $past(lock_in, 2));

  // R6
  stat_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C_STAT) |-> (bus_rdata[M_W+P_W-1:0] == {pll_p, pll_m}
      && bus_rdata[9:8] == {pll_conn, pll_en} && bus_rdata[7] == 1'b0
      && bus_rdata[DATA_W-1:11] == '0));

  // R9
  feed_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C_FEED) |-> (bus_rdata == '0));

  // R1
  rst_sel_chk: assert property (@(posedge clk)
    !rst_n |=> !clk_sel);

  wire unused_ok = bus_rd;
endmodule

bind pll_feed_regs pll_feed_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .M_W(M_W), .P_W(P_W)) u_chk (.*);

// File: tb/tb_pll_feed_regs.sv
`timescale 1ns/1ps
module tb_pll_feed_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lock_in = 1'b0;
  logic        pll_en, pll_conn, clk_sel;
  logic [4:0]  pll_m;
  logic [1:0]  pll_p;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_feed_regs dut (.*);

  localparam logic [8:0] VEC [6] = '{
    {2'b01, 7'h1F}, {2'b11, 7'h23}, {2'b10, 7'h45},
    {2'b11, 7'h7F}, {2'b00, 7'h00}, {2'b11, 7'h6A}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] stat_of(logic [1:0] c, logic [6:0] g, logic lk);
    return {21'd0, lk, c[1], c[0], 1'b0, g};
  endfunction

  function automatic logic [31:0] outs();
    return {22'd0, clk_sel, pll_conn, pll_en, pll_p, pll_m};
  endfunction

  task automatic feed();
    wr(4'hC, 32'hAA);
    wr(4'hC, 32'h55);
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs", outs(), 32'h0);
    rd(4'h0, r); check("R1 ctl", r, 0);
    rd(4'h4, r); check("R1 cfg", r, 0);
    rd(4'h8, r); check("R1 stat", r, 0);

    lock_in = 1'b1;
    repeat (3) @(negedge clk);
    prev = stat_of(2'b00, 7'h00, 1'b1);
    foreach (VEC[i]) begin
      logic [1:0] c;
      logic [6:0] g;
      c = VEC[i][8:7];
      g = VEC[i][6:0];
      wr(4'h0, {30'h3FFF_FFFC, c});
      wr(4'h4, 32'hFFFF_FF80 | 32'(g));
      rd(4'h0, r); check("R2 ctl readback", r, {30'd0, c});
      rd(4'h4, r); check("R3 cfg readback", r, {25'd0, g});
      rd(4'h8, r); check("R2 R3 stat unchanged", r, prev);
      feed();
      check("R4 shadow", {27'd0, pll_p, pll_m}, {25'd0, g});
      check("R4 en conn", {30'd0, pll_conn, pll_en}, {30'd0, c});
      check("R8 clk_sel", {31'd0, clk_sel}, {31'd0, c[0] & c[1]});
      rd(4'h8, r); check("R6 status", r, stat_of(c, g, 1'b1));
      prev = r;
    end

    // R5: pending values differ from shadow (last vector: ctl 3, cfg 6A)
    wr(4'h0, 32'h1); wr(4'h4, 32'h15);
    wr(4'hC, 32'hAA); wr(4'hC, 32'h54);
    check("R5 wrong key", outs(), {22'd0, 1'b1, 2'b11, 7'h6A});
    wr(4'hC, 32'h55);
    check("R5 lone 55", outs(), {22'd0, 1'b1, 2'b11, 7'h6A});
    wr(4'hC, 32'hAA); rd(4'h0, r); wr(4'hC, 32'h55);
    check("R5 read between", outs(), {22'd0, 1'b1, 2'b11, 7'h6A});
    wr(4'hC, 32'hAA); wr(4'h0, 32'h1); wr(4'hC, 32'h55);
    check("R5 write between", outs(), {22'd0, 1'b1, 2'b11, 7'h6A});
    rd(4'h8, r); check("R5 status", r, stat_of(2'b11, 7'h6A, 1'b1));

    // R10
    wr(4'hC, 32'hAA);
    repeat (4) @(negedge clk);
    wr(4'hC, 32'h55);
    check("R10 idle gap commit", outs(), {22'd0, 1'b0, 2'b01, 7'h15});

    // R8: enable only, locked -> bypass
    check("R8 enable only", {31'd0, clk_sel}, 32'd0);
    wr(4'h0, 32'h3); feed();
    check("R8 all set", {31'd0, clk_sel}, 32'd1);

    // R7
    @(negedge clk); lock_in = 1'b0;
    @(negedge clk);
    bus_addr = 4'h8; #1;
    check("R7 one edge", {31'd0, bus_rdata[10]}, 32'd1);
    @(negedge clk); #1;
    check("R7 two edges", {31'd0, bus_rdata[10]}, 32'd0);
    check("R8 lock lost", {31'd0, clk_sel}, 32'd0);

    // R9
    rd(4'hC, r); check("R9 feed read", r, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule